// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column addresses of one burst access to an open bank of a synchronous DRAM. A controller gives it a start column, a length code and an ordering bit together with a one-cycle start strobe. The block then presents one column per beat on a valid/ready output stream. It flags the final beat of fixed-length bursts. A stop input cuts any burst short.

Three fixed lengths are available (2, 4 and 8 beats), in either a sequential or an interleaved ordering, and there is a page mode. A page burst runs over all 256 columns and wraps until it is stopped. Page mode is accepted only in sequential order and only from an even column. Any other page request is refused with a one-cycle error pulse and produces no beats.

Back-pressure rules: a beat is transferred on a rising edge where `out_valid_o` and `out_ready_i` are both high. While `out_valid_o` is high and `out_ready_i` is low, the column and last flag are held, and the burst does not advance. `out_valid_o` never depends on `out_ready_i`.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `out_valid_o`, `out_last_o` and `err_o` are all low.
- R2: Length code `blen_i` encodes 0 = 2 beats, 1 = 4 beats, 2 = 8 beats, 3 = page. A fixed-length burst delivers exactly that many beats, and `out_last_o` is high with the final beat only.
- R3: In sequential order (`order_i` = 0), beat n carries the start column with its low log2(length) bits replaced by (those bits + n) modulo the length. The upper bits stay unchanged.
- R4: In interleaved order (`order_i` = 1), beat n carries the start column XOR n, so only the low log2(length) bits change.
- R5: A page burst (code 3, sequential, even start) yields start, start+1, … modulo 256 and keeps wrapping until stopped. `out_last_o` never rises during it.
- R6: A page request with `order_i` = 1, or with an odd start column, makes `err_o` high for the one cycle after the start edge and generates no beats.
- R7: While `out_valid_o` is high and `out_ready_i` low (and no stop), the column and last flag remain unchanged, and the burst does not advance.
- R8: With `stop_i` high at an edge during a burst, `out_valid_o` is low from the next cycle. A beat handshaken at that same edge still counts. `stop_i` while idle has no effect.
- R9: A start strobe that arrives while a burst is in progress is ignored, and the running burst is unaffected.
- R10: An accepted start makes the first beat valid in the cycle immediately after the start edge. A new start is accepted in the first cycle after a burst has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| start_col_i | input | COL_W (8) | First column of the burst |
| blen_i | input | 2 | Length code: 0=2, 1=4, 2=8, 3=page |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| stop_i | input | 1 | Ends the current burst |
| err_o | output | 1 | One-cycle pulse for a refused page request |
| out_valid_o | output | 1 | Column beat valid |
| out_ready_i | input | 1 | Consumer accepts the beat |
| out_col_o | output | COL_W (8) | Column address of the current beat |
| out_last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
On every cycle, the assertions check the stream rules. These are: holding under stall, no valid after a stop or after a transferred last beat, no beat alongside an error, no last flag in page mode, fixed upper bits within a fixed burst, and a +1 step per page beat. Only the bench's scenarios can show the exact column order for each length and ordering, the beat counts, the wrap past column 255, the refusal of both illegal page requests, and the ignored mid-burst start.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    BL_2    = 2'd0,
    BL_4    = 2'd1,
    BL_8    = 2'd2,
    BL_PAGE = 2'd3
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } bord_e;
endpackage

// File: rtl/bcg_legal.sv
module bcg_legal
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] col_i,
  input  blen_e            len_i,
  input  bord_e            ord_i,
  output logic             bad_o
);
  // page bursts only run sequentially from an even column
  always_comb begin
    bad_o = 1'b0;
    if (len_i == BL_PAGE)
      bad_o = (ord_i == ORD_ILV) || col_i[0];
  end
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  blen_e            len_i,
  input  bord_e            ord_i,
  output logic [COL_W-1:0] col_o,
  output logic             at_end_o
);
  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  always_comb begin
    unique case (len_i)
      BL_2:    wrap_mask = COL_W'(1);
      BL_4:    wrap_mask = COL_W'(3);
      BL_8:    wrap_mask = COL_W'(7);
      default: wrap_mask = '1;
    endcase
  end

  assign seq_col  = (base_i & ~wrap_mask) | ((base_i + cnt_i) & wrap_mask);
  assign ilv_col  = base_i ^ (cnt_i & wrap_mask);
  assign col_o    = (ord_i == ORD_ILV) ? ilv_col : seq_col;
  assign at_end_o = (len_i != BL_PAGE) && ((cnt_i & wrap_mask) == wrap_mask);
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bad_i,
  input  logic             stop_i,
  input  logic             ready_i,
  input  logic             final_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic [COL_W-1:0] cnt_o,
  output logic             err_o
);
  assign accept_o = start_i && !busy_o && !bad_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      err_o  <= 1'b0;
    end else begin
      err_o <= start_i && !busy_o && bad_i;
      if (accept_o) begin
        busy_o <= 1'b1;
        cnt_o  <= '0;
      end else if (busy_o) begin
        if (stop_i) begin
          busy_o <= 1'b0;
        end else if (ready_i) begin
          if (final_i) busy_o <= 1'b0;
          else         cnt_o  <= cnt_o + COL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             order_i,
  input  logic             stop_i,
  output logic             err_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [COL_W-1:0] out_col_o,
  output logic             out_last_o
);
  blen_e            len_in;
  bord_e            ord_in;
  blen_e            len_q;
  bord_e            ord_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt;
  logic             bad;
  logic             busy;
  logic             accept;
  logic             at_end;

  assign len_in = blen_e'(blen_i);
  assign ord_in = bord_e'(order_i);

  bcg_legal #(.COL_W(COL_W)) u_legal (
    .col_i (start_col_i),
    .len_i (len_in),
    .ord_i (ord_in),
    .bad_o (bad)
  );

  bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .bad_i    (bad),
    .stop_i   (stop_i),
    .ready_i  (out_ready_i),
    .final_i  (at_end),
    .busy_o   (busy),
    .accept_o (accept),
    .cnt_o    (cnt),
    .err_o    (err_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= BL_2;
      ord_q  <= ORD_SEQ;
    end else if (accept) begin
      base_q <= start_col_i;
      len_q  <= len_in;
      ord_q  <= ord_in;
    end
  end

  bcg_addr #(.COL_W(COL_W)) u_addr (
    .base_i   (base_q),
    .cnt_i    (cnt),
    .len_i    (len_q),
    .ord_i    (ord_q),
    .col_o    (out_col_o),
    .at_end_o (at_end)
  );

  assign out_valid_o = busy;
  assign out_last_o  = busy && at_end;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic             err_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [COL_W-1:0] out_col_o,
  input logic             out_last_o,
  input logic [1:0]       len_q
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && !stop_i |=> out_valid_o && $stable(out_col_o) && $stable(out_last_o)); // R7
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && stop_i |=> !out_valid_o); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o); // R2
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> out_valid_o); // R2
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !out_valid_o); // R6
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && len_q == 2'd3 |-> !out_last_o); // R5
  AST_FIXED_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i && !out_last_o && !stop_i && len_q != 2'd3
    |=> out_col_o[COL_W-1:3] == $past(out_col_o[COL_W-1:3])); // R3
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_ready_i && !stop_i && len_q == 2'd3
    |=> out_col_o == $past(out_col_o) + COL_W'(1)); // R5
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_i      (stop_i),
  .err_o       (err_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_col_o   (out_col_o),
  .out_last_o  (out_last_o),
  .len_q       (len_q)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [1:0] blen_i = '0;
  logic       order_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       err_o;
  logic       out_valid_o;
  logic       out_ready_i = 1'b0;
  logic [7:0] out_col_o;
  logic       out_last_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .order_i(order_i), .stop_i(stop_i), .err_o(err_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_col_o(out_col_o), .out_last_o(out_last_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int beats_of(int code);
    return (code == 3) ? 256 : (2 << code);
  endfunction

  function automatic int exp_col(int col, int len, int ord, int n);
    int base = col - (col % len);
    int off  = col % len;
    if (ord == 1) return base + (off ^ n);
    return base + ((off + n) % len);
  endfunction

  task automatic do_start(int col, int code, int ord);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 8'(col); blen_i = 2'(code); order_i = ord[0];
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic collect(int col, int code, int ord, string req);
    int len = beats_of(code);
    out_ready_i = 1'b1;
    check({"R10 first beat valid ", req}, out_valid_o, 1);
    for (int n = 0; n < len; n++) begin
      check({req, " valid"}, out_valid_o, 1);
      check({req, " col"}, out_col_o, exp_col(col, len, ord, n));
      check({"R2 last ", req}, out_last_o, (n == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    check({"R2 end ", req}, out_valid_o, 0);
  endtask

  task automatic t_reset();
    check("R1 valid", out_valid_o, 0);
    check("R1 last", out_last_o, 0);
    check("R1 err", err_o, 0);
  endtask

  task automatic t_seq();
    do_start(8'h41, 0, 0); collect(8'h41, 0, 0, "R3 bl2");
    do_start(8'h16, 1, 0); collect(8'h16, 1, 0, "R3 bl4");
    do_start(8'h2D, 2, 0); collect(8'h2D, 2, 0, "R3 bl8");
  endtask

  task automatic t_ilv();
    do_start(8'h2D, 2, 1); collect(8'h2D, 2, 1, "R4 bl8");
    do_start(8'h16, 1, 1); collect(8'h16, 1, 1, "R4 bl4");
    do_start(8'h07, 0, 1); collect(8'h07, 0, 1, "R4 bl2");
  endtask

  task automatic t_page();
    out_ready_i = 1'b1;
    do_start(8'hFE, 3, 0);
    for (int n = 0; n < 260; n++) begin
      check("R5 page valid", out_valid_o, 1);
      check("R5 page col", out_col_o, (8'hFE + n) % 256);
      check("R5 page no last", out_last_o, 0);
      @(negedge clk);
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check("R8 page stopped", out_valid_o, 0);
  endtask

  task automatic t_illegal(int col, int ord, string req);
    do_start(col, 3, ord);
    check({"R6 err pulse ", req}, err_o, 1);
    check({"R6 no beat ", req}, out_valid_o, 0);
    @(negedge clk);
    check({"R6 err drop ", req}, err_o, 0);
    check({"R6 still idle ", req}, out_valid_o, 0);
  endtask

  task automatic t_stall();
    out_ready_i = 1'b0;
    do_start(8'h35, 1, 0);
    for (int k = 0; k < 3; k++) begin
      check("R7 held valid", out_valid_o, 1);
      check("R7 held col", out_col_o, 8'h35);
      check("R7 held last", out_last_o, 0);
      @(negedge clk);
    end
    collect(8'h35, 1, 0, "R7 after stall");
  endtask

  task automatic t_stop();
    out_ready_i = 1'b1;
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check("R8 idle stop no beat", out_valid_o, 0);
    check("R8 idle stop no err", err_o, 0);
    do_start(8'h00, 2, 1);
    for (int n = 0; n < 3; n++) begin
      check("R8 pre-stop col", out_col_o, n);
      @(negedge clk);
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check("R8 stop ends", out_valid_o, 0);
    do_start(8'h41, 0, 0); collect(8'h41, 0, 0, "R8 after idle stop");
  endtask

  task automatic t_busy_start();
    out_ready_i = 1'b1;
    do_start(8'h10, 2, 0);
    for (int n = 0; n < 8; n++) begin
      check("R9 col", out_col_o, 8'h10 + n);
      check("R9 last", out_last_o, (n == 7) ? 1 : 0);
      if (n == 2) begin
        start_i = 1'b1; start_col_i = 8'h80; blen_i = 2'd0; order_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check("R9 ends after 8", out_valid_o, 0);
    check("R9 no err", err_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_page();
    t_illegal(8'h20, 1, "ilv");
    t_illegal(8'h21, 0, "odd");
    t_stall();
    t_stop();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule